// File: doc/BRIEF.md
# Circular Queue Pointer Registers

This block holds the producer and consumer pointers of a circular queue whose entries live in memory. The queue has a run-time power-of-two depth and entries of fixed size. Software reaches the block through a plain word-wide register port with a write strobe, a write select and a combinational read select. Software sets a 64-bit base address, the log2 depth, both pointers and an enable bit there. Two single-cycle side-band pulses from hardware each advance one pointer by one entry.

Each pointer is an index with one wrap bit placed just above it. From the two pointers the block derives registered full and empty flags. It also derives the byte address of the next entry to read (from the consumer) and of the next entry to write (from the producer). The consumer word also carries a seven-bit error code. A dedicated port can set that code. It stays put through any number of consumer steps and changes only when software rewrites the consumer word. The block moves no entry data and raises no interrupts.

Top module: `cqp_queue_ptrs`

## Requirements
- R1: After reset both pointers, the log2 depth, the enable bit, the error code and the overflow flag are zero, `q_empty` is 1 and `q_full` is 0.
- R2: `q_empty` is 1 exactly when producer and consumer agree on all bits [L:0], where L is the current log2 depth (index in bits [L-1:0], wrap bit at bit L).
- R3: `q_full` is 1 exactly when the two index fields agree and the two wrap bits differ.
- R4: An accepted producer step sets the producer to (producer + 1) modulo 2^(L+1), so the wrap bit toggles each time the index rolls past 2^L - 1.
- R5: An accepted consumer step changes only consumer bits [L:0]; the error code in consumer bits [30:24] keeps its value.
- R6: A producer step while the queue is full leaves the producer unchanged and sets `q_overflow`; the flag stays set until software writes the producer register (select 3).
- R7: A consumer step while the queue is empty leaves the consumer unchanged.
- R8: Each entry address is the base with bits [63:52] and [5:0] cleared, plus ENTRY_BYTES times the index of the pointer concerned. The base is written through select 0 (low word) and select 1 (high word) and reads back as written.
- R9: A write to the log2 depth (select 2) larger than MAX_LOG2 stores MAX_LOG2; smaller values are stored unchanged.
- R10: A software write to the producer (select 3) or consumer (select 4) keeps only data bits [L:0] of the pointer. A consumer write also loads the error code from data bits [30:24]. Bit 31 and the bits between L+1 and 23 are dropped.
- R11: A pulse on `err_set` loads `err_code` into the error field (codes 0 none, 1 illegal command, 2 abort, 3 invalidate-sync failure). A later consumer software write replaces it, and a software write wins over `err_set` in the same cycle.
- R12: `q_full`, `q_empty` and both entry addresses are registered. They reflect a pointer, depth or base change one clock after the edge at which that register changed.
- R13: Bit 0 of a write to select 5 sets `q_enable`, and select 5 reads it back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 base low, 1 base high, 2 log2 depth, 3 producer, 4 consumer, 5 control |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Read select, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational read data |
| prod_inc | input | 1 | Hardware request to advance the producer |
| cons_inc | input | 1 | Hardware request to advance the consumer |
| err_set | input | 1 | Load `err_code` into the consumer error field |
| err_code | input | 7 | Error code to load |
| q_enable | output | 1 | Queue enable bit |
| q_full | output | 1 | Registered full flag |
| q_empty | output | 1 | Registered empty flag |
| q_overflow | output | 1 | Sticky flag for a dropped producer step |
| rd_entry_addr | output | 64 | Byte address of the next entry to consume |
| wr_entry_addr | output | 64 | Byte address of the next entry to produce |

## Verification
The bench builds the block with MAX_LOG2 = 3 and ENTRY_BYTES = 32. With these values every legal depth from one to eight entries can be filled, overrun, drained, underrun and driven through a complete wrap of both pointers in a few hundred cycles. The small limit also lets a single write test the depth clamp and the masking of the upper pointer bits. Expected pointers, flags and addresses are computed as modular arithmetic on a bench-side model of the two pointers.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

  // register select encoding on the software port
  typedef enum logic [2:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_LOG2    = 3'd2,
    SEL_PROD    = 3'd3,
    SEL_CONS    = 3'd4,
    SEL_CTRL    = 3'd5
  } reg_sel_e;

  // error codes kept in the consumer word
  typedef enum logic [6:0] {
    ERR_NONE     = 7'd0,
    ERR_ILLEGAL  = 7'd1,
    ERR_ABORT    = 7'd2,
    ERR_SYNC_INV = 7'd3
  } err_code_e;

  localparam int ERR_LSB = 24;
  localparam int ERR_W   = 7;
  localparam int ADDR_W  = 64;
  // base keeps address bits [51:6]
  localparam logic [ADDR_W-1:0] BASE_MASK = ((64'd1 << 52) - 64'd1) & ~64'h3F;

endpackage

// File: rtl/cqp_ptr.sv
module cqp_ptr #(
  parameter int PTR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [PTR_W-1:0] sw_val,
  input  logic [PTR_W-1:0] wim,
  input  logic             inc_req,
  input  logic             inc_ok,
  output logic [PTR_W-1:0] ptr_o
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = sw_wr | (inc_req & inc_ok);
    if (sw_wr) ptr_d = sw_val & wim;
    else       ptr_d = (ptr_q + 1'b1) & wim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R6 / R7: a refused step leaves the pointer alone
  a_r7_refused_inc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !inc_ok && !sw_wr) |=> $stable(ptr_q));

  // R4: pointer moves only on a step or a software write
  a_r4_ptr_moves_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_req && !sw_wr) |=> $stable(ptr_q));

endmodule

// File: rtl/cqp_err_field.sv
module cqp_err_field #(
  parameter int ERR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [ERR_W-1:0] sw_val,
  input  logic             set_en,
  input  logic [ERR_W-1:0] set_val,
  output logic [ERR_W-1:0] err_o
);

  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_d;
  logic             err_en;

  always_comb begin
    err_en = sw_wr | set_en;
    err_d  = sw_wr ? sw_val : set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  assign err_o = err_q;

  // R5 / R11: nothing but the two writers touches the code
  a_r5_err_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !set_en) |=> $stable(err_q));

endmodule

// File: rtl/cqp_status.sv
module cqp_status #(
  parameter int MAX_LOG2    = 19,
  parameter int ENTRY_BYTES = 16,
  parameter int ADDR_W      = 64,
  localparam int PTR_W      = MAX_LOG2 + 1,
  localparam int LOG2_W     = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG2_W-1:0] log2_sz,
  input  logic [ADDR_W-1:0] base_m,
  input  logic [PTR_W-1:0]  prod,
  input  logic [PTR_W-1:0]  cons,
  output logic [PTR_W-1:0]  wim_o,
  output logic              full_c_o,
  output logic              empty_c_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);

  logic [LOG2_W-1:0] shamt;
  logic [PTR_W-1:0]  wim, idx_mask, wrap_bit, diff;
  logic              full_c, empty_c;
  logic [ADDR_W-1:0] rd_addr_d, wr_addr_d;
  logic              full_q, empty_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;

  always_comb begin
    shamt     = LOG2_W'(MAX_LOG2) - log2_sz;
    wim       = {PTR_W{1'b1}} >> shamt;
    idx_mask  = wim >> 1;
    wrap_bit  = idx_mask + 1'b1;
    diff      = (prod ^ cons) & wim;
    full_c    = (diff == wrap_bit);
    empty_c   = (diff == '0);
    rd_addr_d = base_m + ADDR_W'(cons & idx_mask) * ADDR_W'(ENTRY_BYTES);
    wr_addr_d = base_m + ADDR_W'(prod & idx_mask) * ADDR_W'(ENTRY_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
    end else begin
      full_q    <= full_c;
      empty_q   <= empty_c;
      rd_addr_q <= rd_addr_d;
      wr_addr_q <= wr_addr_d;
    end
  end

  assign wim_o     = wim;
  assign full_c_o  = full_c;
  assign empty_c_o = empty_c;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign rd_addr_o = rd_addr_q;
  assign wr_addr_o = wr_addr_q;

  // R2 / R3: the registered flags never both assert
  a_r3_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));

endmodule

// File: rtl/cqp_queue_ptrs.sv
module cqp_queue_ptrs
  import cqp_pkg::*;
#(
  parameter int MAX_LOG2    = 19,
  parameter int ENTRY_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        prod_inc,
  input  logic        cons_inc,
  input  logic        err_set,
  input  logic [6:0]  err_code,
  output logic        q_enable,
  output logic        q_full,
  output logic        q_empty,
  output logic        q_overflow,
  output logic [63:0] rd_entry_addr,
  output logic [63:0] wr_entry_addr
);

  localparam int PTR_W  = MAX_LOG2 + 1;
  localparam int LOG2_W = $clog2(MAX_LOG2 + 1);

  logic [31:0]       base_lo_q, base_hi_q;
  logic [LOG2_W-1:0] log2_q, log2_d;
  logic              en_q, ovf_q, ovf_d, ovf_en;
  logic              wr_lo, wr_hi, wr_log2, wr_prod, wr_cons, wr_ctrl;
  logic [ADDR_W-1:0] base_m;
  logic [PTR_W-1:0]  wim, prod_ptr, cons_ptr;
  logic              full_c, empty_c;
  logic [ERR_W-1:0]  err_val;

  // write decode
  always_comb begin
    wr_lo   = wr_en && (wr_sel == SEL_BASE_LO);
    wr_hi   = wr_en && (wr_sel == SEL_BASE_HI);
    wr_log2 = wr_en && (wr_sel == SEL_LOG2);
    wr_prod = wr_en && (wr_sel == SEL_PROD);
    wr_cons = wr_en && (wr_sel == SEL_CONS);
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  end

  // next-state for the configuration and overflow registers
  always_comb begin
    if (wr_data > 32'(MAX_LOG2)) log2_d = LOG2_W'(MAX_LOG2);
    else                         log2_d = wr_data[LOG2_W-1:0];
    ovf_en = wr_prod | (prod_inc & full_c);
    ovf_d  = ~wr_prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      log2_q    <= '0;
      en_q      <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (wr_lo)   base_lo_q <= wr_data;
      if (wr_hi)   base_hi_q <= wr_data;
      if (wr_log2) log2_q    <= log2_d;
      if (wr_ctrl) en_q      <= wr_data[0];
      if (ovf_en)  ovf_q     <= ovf_d;
    end
  end

  assign base_m = {base_hi_q, base_lo_q} & BASE_MASK;

  cqp_status #(
    .MAX_LOG2   (MAX_LOG2),
    .ENTRY_BYTES(ENTRY_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .log2_sz  (log2_q),
    .base_m   (base_m),
    .prod     (prod_ptr),
    .cons     (cons_ptr),
    .wim_o    (wim),
    .full_c_o (full_c),
    .empty_c_o(empty_c),
    .full_o   (q_full),
    .empty_o  (q_empty),
    .rd_addr_o(rd_entry_addr),
    .wr_addr_o(wr_entry_addr)
  );

  cqp_ptr #(.PTR_W(PTR_W)) u_prod (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_wr  (wr_prod),
    .sw_val (wr_data[PTR_W-1:0]),
    .wim    (wim),
    .inc_req(prod_inc),
    .inc_ok (~full_c),
    .ptr_o  (prod_ptr)
  );

  cqp_ptr #(.PTR_W(PTR_W)) u_cons (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_wr  (wr_cons),
    .sw_val (wr_data[PTR_W-1:0]),
    .wim    (wim),
    .inc_req(cons_inc),
    .inc_ok (~empty_c),
    .ptr_o  (cons_ptr)
  );

  cqp_err_field #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_wr  (wr_cons),
    .sw_val (wr_data[ERR_LSB+ERR_W-1:ERR_LSB]),
    .set_en (err_set),
    .set_val(err_code),
    .err_o  (err_val)
  );

  // read mux
  always_comb begin
    case (rd_sel)
      SEL_BASE_LO: rd_data = base_lo_q;
      SEL_BASE_HI: rd_data = base_hi_q;
      SEL_LOG2:    rd_data = 32'(log2_q);
      SEL_PROD:    rd_data = 32'(prod_ptr);
      SEL_CONS:    rd_data = 32'(cons_ptr) | (32'(err_val) << ERR_LSB);
      SEL_CTRL:    rd_data = {31'd0, en_q};
      default:     rd_data = '0;
    endcase
  end

  assign q_enable   = en_q;
  assign q_overflow = ovf_q;

  // R6: overflow flag holds until a producer write
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !wr_prod) |=> ovf_q);

  // R9: stored depth never exceeds the limit
  a_r9_size_within_max: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(log2_q) <= 32'(MAX_LOG2)));

endmodule

// File: tb/cqp_queue_ptrs_bench.sv
module cqp_queue_ptrs_bench;
  import cqp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 3;
  localparam int EB   = 32;

  logic        clk, rst_n, wr_en, prod_inc, cons_inc, err_set;
  logic [2:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [6:0]  err_code;
  logic        q_enable, q_full, q_empty, q_overflow;
  logic [63:0] rd_entry_addr, wr_entry_addr;

  int n_tests, n_fail;
  bit done;

  cqp_queue_ptrs #(.MAX_LOG2(MAXL), .ENTRY_BYTES(EB)) u_cqp_queue_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .prod_inc(prod_inc), .cons_inc(cons_inc),
    .err_set(err_set), .err_code(err_code), .q_enable(q_enable), .q_full(q_full),
    .q_empty(q_empty), .q_overflow(q_overflow), .rd_entry_addr(rd_entry_addr),
    .wr_entry_addr(wr_entry_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic push();
    @(negedge clk); prod_inc = 1'b1;
    @(negedge clk); prod_inc = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); cons_inc = 1'b1;
    @(negedge clk); cons_inc = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] base_exp;
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    prod_inc = 1'b0; cons_inc = 1'b0; err_set = 1'b0; err_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", 64'(q_empty), 1);
    chk("R1 full", 64'(q_full), 0);
    chk("R1 overflow", 64'(q_overflow), 0);
    chk("R1 enable", 64'(q_enable), 0);
    rd(SEL_PROD, v); chk("R1 prod", 64'(v), 0);
    rd(SEL_CONS, v); chk("R1 cons", 64'(v), 0);
    rd(SEL_LOG2, v); chk("R1 log2", 64'(v), 0);

    // R8 base masking and readback
    wr(SEL_BASE_LO, 32'h6789ABFF);
    wr(SEL_BASE_HI, 32'hFFF12345);
    settle();
    base_exp = 64'h0001_2345_6789_ABC0;
    rd(SEL_BASE_LO, v); chk("R8 base lo readback", 64'(v), 64'h6789ABFF);
    rd(SEL_BASE_HI, v); chk("R8 base hi readback", 64'(v), 64'hFFF12345);
    chk("R8 rd addr at base", rd_entry_addr, base_exp);
    chk("R8 wr addr at base", wr_entry_addr, base_exp);

    // R13 enable
    wr(SEL_CTRL, 32'hFFFF_FFFF);
    chk("R13 enable set", 64'(q_enable), 1);
    rd(SEL_CTRL, v); chk("R13 enable readback", 64'(v), 1);
    wr(SEL_CTRL, 32'h0);
    chk("R13 enable clear", 64'(q_enable), 0);

    // R9 clamp
    wr(SEL_LOG2, 32'd25);
    rd(SEL_LOG2, v); chk("R9 clamp", 64'(v), MAXL);
    wr(SEL_LOG2, 32'd2);
    rd(SEL_LOG2, v); chk("R9 in range", 64'(v), 2);

    // R10 masking of software writes at depth 4
    wr(SEL_PROD, 32'hFFFF_FFFF);
    rd(SEL_PROD, v); chk("R10 prod mask", 64'(v), 7);
    wr(SEL_CONS, 32'hC100_00FD);
    rd(SEL_CONS, v); chk("R10 cons mask and err", 64'(v), 64'h4100_0005);
    wr(SEL_PROD, 32'h0);
    wr(SEL_CONS, 32'h0);
    settle();

    // R12 registered lag
    @(negedge clk); prod_inc = 1'b1;
    @(negedge clk); prod_inc = 1'b0;
    rd(SEL_PROD, v); chk("R12 ptr already moved", 64'(v), 1);
    chk("R12 empty not yet updated", 64'(q_empty), 1);
    @(negedge clk);
    chk("R12 empty updated one clock later", 64'(q_empty), 0);
    chk("R12 wr addr updated", wr_entry_addr, base_exp + 64'(EB));

    // sweep every depth
    for (int lg = 0; lg <= MAXL; lg++) begin
      int depth, modv, ep, ec;
      depth = 1 << lg; modv = 2 * depth; ep = 0; ec = 0;
      wr(SEL_LOG2, 32'(lg));
      wr(SEL_PROD, 32'h0);
      wr(SEL_CONS, 32'h0);
      settle();
      chk("R6 overflow cleared by producer write", 64'(q_overflow), 0);
      chk("R2 empty after reload", 64'(q_empty), 1);

      // R11 error port
      @(negedge clk); err_set = 1'b1; err_code = ERR_ABORT;
      @(negedge clk); err_set = 1'b0; err_code = '0;
      rd(SEL_CONS, v); chk("R11 err set", 64'(v), 64'(32'd2 << 24));

      for (int k = 0; k < depth; k++) begin
        push();
        ep = (ep + 1) % modv;
        rd(SEL_PROD, v); chk("R4 prod step", 64'(v), 64'(ep));
        chk("R3 full while filling", 64'(q_full), 64'(k == depth - 1));
        chk("R2 not empty while filling", 64'(q_empty), 0);
        chk("R8 wr addr", wr_entry_addr, base_exp + 64'(EB * (ep % depth)));
      end
      push();
      rd(SEL_PROD, v); chk("R6 push dropped when full", 64'(v), 64'(ep));
      chk("R6 overflow set", 64'(q_overflow), 1);
      chk("R3 still full", 64'(q_full), 1);

      for (int k = 0; k < depth; k++) begin
        pop();
        ec = (ec + 1) % modv;
        rd(SEL_CONS, v); chk("R5 cons step keeps err", 64'(v), 64'((32'd2 << 24) | 32'(ec)));
        chk("R8 rd addr", rd_entry_addr, base_exp + 64'(EB * (ec % depth)));
        chk("R2 empty while draining", 64'(q_empty), 64'(k == depth - 1));
        chk("R6 overflow stays", 64'(q_overflow), 1);
      end
      pop();
      rd(SEL_CONS, v); chk("R7 pop dropped when empty", 64'(v), 64'((32'd2 << 24) | 32'(ec)));
      chk("R7 still empty", 64'(q_empty), 1);

      for (int k = 0; k < depth; k++) begin
        push();
        ep = (ep + 1) % modv;
      end
      rd(SEL_PROD, v); chk("R4 producer wrapped to zero", 64'(v), 0);
      chk("R3 full across wrap", 64'(q_full), 1);
      chk("R2 not empty across wrap", 64'(q_empty), 0);

      wr(SEL_CONS, 32'h0);
      rd(SEL_CONS, v); chk("R11 err replaced by cons write", 64'(v), 0);
    end

    // R11 software write wins over err_set
    @(negedge clk);
    err_set = 1'b1; err_code = ERR_ILLEGAL;
    wr_en = 1'b1; wr_sel = SEL_CONS; wr_data = 32'h0300_0000;
    @(negedge clk);
    err_set = 1'b0; wr_en = 1'b0;
    rd(SEL_CONS, v); chk("R11 software write priority", 64'(v), 64'h0300_0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule